// File: doc/BRIEF.md
# Priority-Level Interrupt Arbiter

This block sits between a processor core and its maskable interrupt sources and decides which request the core takes next. Every source carries a 3-bit level set by software. Level 0 switches a source off, and levels 1 to 7 rank it, with 7 ranking highest. Internal peripherals raise requests through one-cycle strobes, which the block latches. External pins pass through a synchronizer. Each pin can be set to edge or level sensing and to either polarity.

When a usable request is pending, the block opens a detection window. Software selects the window length. At the end of the window, the block compares all pending sources with one another and picks the highest level. It then checks that level against the processor's running priority level and the global disable flag. If the request passes, the block raises a one-cycle accept strobe. The strobe carries the source index and the level that becomes the new processor priority level. The core feeds that level back as the running level, which allows nesting.

Top module: `ipa_arbiter`

## Requirements
- R1: While reset is asserted, and right after it, `accept` is 0 and `accept_idx` and `new_ipl` are 0.
- R2: Among the requests pending when a window ends, the one with the highest level wins. Source index k takes its level from `src_level[3k+2:3k]`. External pin i is source i. Internal strobe bit j is source `NUM_EXT+j`, which is 3+j by default.
- R3: When pending sources have equal levels, the one with the lowest source index wins.
- R4: A source whose level is 0 is never accepted and never blocks another source.
- R5: The winner is accepted only when its level is strictly greater than `cur_ipl`. A winner whose level equals or is below `cur_ipl` gives no accept.
- R6: While `irq_disable` is 1, no request is accepted.
- R7: An acceptance is one `accept` cycle. In that cycle `accept_idx` carries the source index and `new_ipl` carries the winner's level.
- R8: The window length is W = 2^(det_sel+1) cycles. An internal strobe sampled at clock edge E gives `accept` at edge E+W+1 when nothing else is pending, and not before.
- R9: With `ext_level_sense[i]`=0, pin i makes a request on its active edge only. The active edge is rising when `ext_active_high[i]`=1 and falling when it is 0. The opposite edge is ignored. One edge gives exactly one accept, because acceptance clears the request.
- R10: With `ext_level_sense[i]`=1, pin i requests for as long as its synchronized level equals `ext_active_high[i]`. It is accepted again and again while it holds that level, and never while it holds the other level.
- R11: An internal request that cannot be accepted (because it is blocked or loses arbitration) stays pending. It is taken once the block lifts. Acceptance clears only the winner's request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| int_req_set | input | NUM_INT | One-cycle request strobes from internal sources |
| ext_pin | input | NUM_EXT | Asynchronous external interrupt pins |
| ext_level_sense | input | NUM_EXT | 1 = level sensing, 0 = edge sensing, per pin |
| ext_active_high | input | NUM_EXT | 1 = rising edge or high level is active, 0 = falling edge or low level is active |
| src_level | input | NUM_SRC*3 | Packed per-source levels, with source k in bits 3k+2:3k |
| irq_disable | input | 1 | Global mask for all maskable requests |
| cur_ipl | input | 3 | Running processor priority level |
| det_sel | input | DET_W | Detection window select, giving a window of 2^(det_sel+1) cycles |
| accept | output | 1 | One-cycle acceptance strobe |
| accept_idx | output | 5 | Index of the accepted source |
| new_ipl | output | 3 | Level of the accepted source, to become the processor level |

## Verification
The bench targets several corner cases:

- **Equal levels.** A comparator that used greater-or-equal would hand the grant to the higher index.
- **Level equal to `cur_ipl`.** A design that let this through would break nesting.
- **Level 0 beside a level-1 source.** A design that treated 0 as a valid rank would pick the wrong source or fire on a disabled one.
- **Window length.** Each window setting is timed to the exact edge, and an early strobe is counted as an error. This catches a miscounted window or an extra register.
- **Pin sensing.** A single edge must give exactly one accept, the wrong edge must give none, and a held level must keep re-firing and stop when released. A design that forgot to clear on acceptance, or mixed up the polarity, fails these.
- **Blocked requests.** A request held back by the disable flag must survive and be taken once the flag drops. A design that dropped blocked requests fails this.

// File: rtl/ipa_pkg.sv
package ipa_pkg;
    localparam int LVL_W = 3;
    localparam int IDX_W = 5;
    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [IDX_W-1:0] idx_t;
endpackage

// File: rtl/ipa_ext_sense.sv
// Per-pin synchronizer with selectable edge/level detection and polarity.
module ipa_ext_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic level_mode,
    input  logic active_high,
    input  logic clr,
    output logic req
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
        logic pend;
    } sense_t;

    sense_t sense_d, sense_q;
    logic   act_edge;

    always_comb begin
        act_edge = active_high ? (sense_q.s2 & ~sense_q.prev)
                               : (~sense_q.s2 & sense_q.prev);
        sense_d      = sense_q;
        sense_d.s1   = pin;
        sense_d.s2   = sense_q.s1;
        sense_d.prev = sense_q.s2;
        // a fresh edge wins over a clear in the same cycle
        sense_d.pend = level_mode ? 1'b0 : (act_edge | (sense_q.pend & ~clr));
        req = level_mode ? (sense_q.s2 == active_high) : sense_q.pend;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sense_q <= '0;
        else        sense_q <= sense_d;
    end

    // R9: acceptance removes an edge request when no new edge arrives
    a_r9_edge_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_mode && clr && !act_edge) |=> !sense_q.pend);
endmodule

// File: rtl/ipa_level_chain.sv
// Successive-comparison chain: each stage keeps the best (level, index) so far.
module ipa_level_chain
    import ipa_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0]       req,
    input  logic [N*LVL_W-1:0] lvl_flat,
    output logic               found,
    output idx_t               win_idx,
    output lvl_t               win_lvl
);
    lvl_t best_lvl [0:N];
    idx_t best_idx [0:N];

    assign best_lvl[0] = '0;
    assign best_idx[0] = '0;

    for (genvar i = 0; i < N; i++) begin : g_stage
        lvl_t cand;
        logic take;
        assign cand = req[i] ? lvl_flat[i*LVL_W +: LVL_W] : '0;
        // strict compare keeps the lower index on ties
        assign take = cand > best_lvl[i];
        assign best_lvl[i+1] = take ? cand : best_lvl[i];
        assign best_idx[i+1] = take ? idx_t'(i) : best_idx[i];
    end

    assign win_lvl = best_lvl[N];
    assign win_idx = best_idx[N];
    assign found   = (best_lvl[N] != '0);
endmodule

// File: rtl/ipa_arbiter.sv
module ipa_arbiter
    import ipa_pkg::*;
#(
    parameter int NUM_EXT = 3,
    parameter int NUM_INT = 5,
    parameter int DET_W   = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_INT-1:0]                int_req_set,
    input  logic [NUM_EXT-1:0]                ext_pin,
    input  logic [NUM_EXT-1:0]                ext_level_sense,
    input  logic [NUM_EXT-1:0]                ext_active_high,
    input  logic [(NUM_EXT+NUM_INT)*LVL_W-1:0] src_level,
    input  logic                              irq_disable,
    input  logic [LVL_W-1:0]                  cur_ipl,
    input  logic [DET_W-1:0]                  det_sel,
    output logic                              accept,
    output logic [IDX_W-1:0]                  accept_idx,
    output logic [LVL_W-1:0]                  new_ipl
);
    localparam int NUM_SRC = NUM_EXT + NUM_INT;
    localparam int CNT_W   = 1 << DET_W;

    typedef struct packed {
        logic               busy;
        logic [CNT_W-1:0]   cnt;
        logic [NUM_INT-1:0] pend;
        logic               acc;
        idx_t               idx;
        lvl_t               ipl;
    } arb_t;

    arb_t st_d, st_q;

    logic [NUM_EXT-1:0] ext_req;
    logic [NUM_SRC-1:0] all_req;
    logic [NUM_SRC-1:0] clr_all;
    logic               found;
    idx_t               win_idx;
    lvl_t               win_lvl;
    logic               grant;
    logic [CNT_W:0]     win_len;

    for (genvar i = 0; i < NUM_EXT; i++) begin : g_ext
        ipa_ext_sense u_sense (
            .clk        (clk),
            .rst_n      (rst_n),
            .pin        (ext_pin[i]),
            .level_mode (ext_level_sense[i]),
            .active_high(ext_active_high[i]),
            .clr        (clr_all[i]),
            .req        (ext_req[i])
        );
    end

    assign all_req = {st_q.pend, ext_req};

    ipa_level_chain #(.N(NUM_SRC)) u_chain (
        .req     (all_req),
        .lvl_flat(src_level),
        .found   (found),
        .win_idx (win_idx),
        .win_lvl (win_lvl)
    );

    always_comb begin
        win_len = (CNT_W+1)'(2) << det_sel;
        grant   = st_q.busy && (st_q.cnt == '0) && found &&
                  !irq_disable && (win_lvl > cur_ipl);
        for (int k = 0; k < NUM_SRC; k++)
            clr_all[k] = grant && (win_idx == idx_t'(k));

        st_d      = st_q;
        st_d.acc  = 1'b0;
        st_d.pend = (st_q.pend & ~clr_all[NUM_SRC-1:NUM_EXT]) | int_req_set;

        if (!st_q.busy) begin
            if (found) begin
                st_d.busy = 1'b1;
                st_d.cnt  = CNT_W'(win_len - 1'b1);
            end
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end else begin
            st_d.busy = 1'b0;
            if (grant) begin
                st_d.acc = 1'b1;
                st_d.idx = win_idx;
                st_d.ipl = win_lvl;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign accept     = st_q.acc;
    assign accept_idx = st_q.idx;
    assign new_ipl    = st_q.ipl;

    a_r7_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !accept);
    a_r5_above_ipl: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (new_ipl > $past(cur_ipl)));
    a_r6_disable_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> !$past(irq_disable));
    a_r4_level_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (new_ipl != '0));
    a_r8_window_count: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.cnt != '0) |=>
            (st_q.busy && st_q.cnt == $past(st_q.cnt) - 1'b1));
endmodule

// File: tb/ipa_arbiter_bench.sv
module ipa_arbiter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  int_req_set = '0;
    logic [2:0]  ext_pin = '0;
    logic [2:0]  ext_level_sense = '0;
    logic [2:0]  ext_active_high = 3'b111;
    logic [23:0] src_level = '0;
    logic        irq_disable = 1'b0;
    logic [2:0]  cur_ipl = '0;
    logic [1:0]  det_sel = '0;
    logic        accept;
    logic [4:0]  accept_idx;
    logic [2:0]  new_ipl;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    ipa_arbiter u_ipa_arbiter (
        .clk(clk), .rst_n(rst_n), .int_req_set(int_req_set), .ext_pin(ext_pin),
        .ext_level_sense(ext_level_sense), .ext_active_high(ext_active_high),
        .src_level(src_level), .irq_disable(irq_disable), .cur_ipl(cur_ipl),
        .det_sel(det_sel), .accept(accept), .accept_idx(accept_idx), .new_ipl(new_ipl)
    );

    typedef struct packed {
        logic [3:0]  rq;
        logic [23:0] lvl;
        logic [4:0]  stb;
        logic        dis;
        logic [2:0]  ipl;
        logic [1:0]  det;
        logic        acc;
        logic [4:0]  idx;
        logic [2:0]  nipl;
    } vec_t;

    localparam int NV = 11;
    // level packing: {L7,L6,L5,L4,L3,L2,L1,L0}; strobe bit j = source 3+j
    localparam vec_t VECS [NV] = '{
        '{4'd2,  {3'd0,3'd0,3'd0,3'd5,3'd2,3'd0,3'd0,3'd0}, 5'b00011, 1'b0, 3'd0, 2'd0, 1'b1, 5'd4, 3'd5}, // R2
        '{4'd3,  {3'd0,3'd0,3'd4,3'd4,3'd0,3'd0,3'd0,3'd0}, 5'b00110, 1'b0, 3'd0, 2'd1, 1'b1, 5'd4, 3'd4}, // R3
        '{4'd4,  {3'd0,3'd0,3'd0,3'd0,3'd0,3'd0,3'd0,3'd0}, 5'b00001, 1'b0, 3'd0, 2'd0, 1'b0, 5'd0, 3'd0}, // R4
        '{4'd4,  {3'd1,3'd0,3'd0,3'd0,3'd0,3'd0,3'd0,3'd0}, 5'b10001, 1'b0, 3'd0, 2'd2, 1'b1, 5'd7, 3'd1}, // R4
        '{4'd5,  {3'd0,3'd0,3'd3,3'd0,3'd0,3'd0,3'd0,3'd0}, 5'b00100, 1'b0, 3'd3, 2'd0, 1'b0, 5'd0, 3'd0}, // R5
        '{4'd5,  {3'd0,3'd0,3'd4,3'd0,3'd0,3'd0,3'd0,3'd0}, 5'b00100, 1'b0, 3'd3, 2'd3, 1'b1, 5'd5, 3'd4}, // R5
        '{4'd6,  {3'd0,3'd7,3'd0,3'd0,3'd0,3'd0,3'd0,3'd0}, 5'b01000, 1'b1, 3'd0, 2'd0, 1'b0, 5'd0, 3'd0}, // R6
        '{4'd3,  {3'd2,3'd6,3'd3,3'd6,3'd1,3'd0,3'd0,3'd0}, 5'b11111, 1'b0, 3'd5, 2'd1, 1'b1, 5'd4, 3'd6}, // R3
        '{4'd2,  {3'd7,3'd0,3'd0,3'd0,3'd2,3'd0,3'd0,3'd0}, 5'b10001, 1'b0, 3'd6, 2'd0, 1'b1, 5'd7, 3'd7}, // R2
        '{4'd5,  {3'd0,3'd0,3'd0,3'd0,3'd7,3'd0,3'd0,3'd0}, 5'b00001, 1'b0, 3'd7, 2'd0, 1'b0, 5'd0, 3'd0}, // R5
        '{4'd8,  {3'd0,3'd0,3'd0,3'd1,3'd0,3'd0,3'd0,3'd0}, 5'b00010, 1'b0, 3'd0, 2'd2, 1'b1, 5'd4, 3'd1}  // R8
    };

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        int_req_set = '0;
        irq_disable = 1'b0;
        cur_ipl = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic count_acc(input int cycles, output int cnt, output int last_idx);
        cnt = 0;
        last_idx = -1;
        for (int k = 0; k < cycles; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (accept) begin
                cnt++;
                last_idx = accept_idx;
            end
        end
    endtask

    task automatic wait_acc(input int cycles, output bit got, output int idx, output int lvl);
        got = 1'b0;
        idx = -1;
        lvl = -1;
        for (int k = 0; k < cycles && !got; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (accept) begin
                got = 1'b1;
                idx = accept_idx;
                lvl = new_ipl;
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        int cnt;
        int li;
        bit got;
        int gi;
        int gl;

        // R1: reset state, during and right after reset
        repeat (2) @(negedge clk);
        check(accept == 1'b0 && accept_idx == 5'd0 && new_ipl == 3'd0, "R1",
              int'({accept, accept_idx, new_ipl}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(accept == 1'b0 && accept_idx == 5'd0 && new_ipl == 3'd0, "R1",
              int'({accept, accept_idx, new_ipl}), 0);

        // table of vectors: R2 R3 R4 R5 R6 R8 timing, R7 pulse width
        for (int v = 0; v < NV; v++) begin
            bit early;
            int w;
            do_reset();
            src_level   = VECS[v].lvl;
            irq_disable = VECS[v].dis;
            cur_ipl     = VECS[v].ipl;
            det_sel     = VECS[v].det;
            int_req_set = VECS[v].stb;
            w = 2 << VECS[v].det;
            @(posedge clk);
            @(negedge clk);
            int_req_set = '0;
            early = 1'b0;
            for (int k = 1; k < w; k++) begin
                @(posedge clk);
                @(negedge clk);
                if (accept) early = 1'b1;
            end
            @(posedge clk);
            @(negedge clk);
            if (accept) early = 1'b1;
            check(!early, "R8 (early accept)", int'(early), 0);
            @(posedge clk);
            @(negedge clk);
            n_chk++;
            if (accept !== VECS[v].acc ||
                (VECS[v].acc && (accept_idx !== VECS[v].idx || new_ipl !== VECS[v].nipl))) begin
                n_fail++;
                $display("FAIL R%0d vector %0d: actual acc=%0d idx=%0d ipl=%0d expected acc=%0d idx=%0d ipl=%0d",
                         VECS[v].rq, v, accept, accept_idx, new_ipl,
                         VECS[v].acc, VECS[v].idx, VECS[v].nipl);
            end
            @(posedge clk);
            @(negedge clk);
            check(accept == 1'b0, "R7 (pulse width)", int'(accept), 0);
        end

        // R9: rising edge on pin 0 gives exactly one accept
        ext_level_sense = '0;
        ext_active_high = 3'b111;
        ext_pin = '0;
        det_sel = 2'd0;
        do_reset();
        src_level = {3'd0,3'd0,3'd0,3'd0,3'd0,3'd0,3'd0,3'd3};
        ext_pin[0] = 1'b1;
        wait_acc(40, got, gi, gl);
        check(got && gi == 0 && gl == 3, "R9 (rising edge)", gi, 0);
        count_acc(40, cnt, li);
        check(cnt == 0, "R9 (single accept per edge)", cnt, 0);
        ext_pin[0] = 1'b0;
        count_acc(20, cnt, li);
        check(cnt == 0, "R9 (inactive edge ignored)", cnt, 0);

        // R9: falling-edge pin 1
        ext_active_high = 3'b101;
        ext_pin = 3'b010;
        do_reset();
        src_level = {3'd0,3'd0,3'd0,3'd0,3'd0,3'd0,3'd4,3'd0};
        count_acc(10, cnt, li);
        check(cnt == 0, "R9 (rising ignored in falling mode)", cnt, 0);
        ext_pin[1] = 1'b0;
        wait_acc(40, got, gi, gl);
        check(got && gi == 1 && gl == 4, "R9 (falling edge)", gi, 1);

        // R10: active-low level-sense pin 2
        ext_active_high = 3'b011;
        ext_pin = 3'b100;
        do_reset();
        repeat (4) @(negedge clk);
        ext_level_sense = 3'b100;
        src_level = {3'd0,3'd0,3'd0,3'd0,3'd0,3'd2,3'd0,3'd0};
        count_acc(10, cnt, li);
        check(cnt == 0, "R10 (invalid level)", cnt, 0);
        ext_pin[2] = 1'b0;
        count_acc(60, cnt, li);
        check(cnt >= 3 && li == 2, "R10 (repeated while held)", cnt, 3);
        ext_pin[2] = 1'b1;
        repeat (5) @(negedge clk);
        count_acc(30, cnt, li);
        check(cnt == 0, "R10 (stops on release)", cnt, 0);
        ext_level_sense = '0;
        ext_active_high = 3'b111;
        ext_pin = '0;

        // R11: blocked request survives and is taken once unblocked
        do_reset();
        src_level = {3'd0,3'd5,3'd0,3'd0,3'd0,3'd0,3'd0,3'd0};
        irq_disable = 1'b1;
        int_req_set = 5'b01000;
        @(posedge clk);
        @(negedge clk);
        int_req_set = '0;
        count_acc(30, cnt, li);
        check(cnt == 0, "R11 (held while disabled)", cnt, 0);
        irq_disable = 1'b0;
        wait_acc(20, got, gi, gl);
        check(got && gi == 6 && gl == 5, "R11 (taken after unblock)", gi, 6);

        // R11: loser stays pending after the winner is taken
        do_reset();
        src_level = {3'd0,3'd0,3'd0,3'd0,3'd0,3'd0,3'd0,3'd0} | {3'd3,3'd0,3'd0,3'd0,3'd6,3'd0,3'd0,3'd0};
        int_req_set = 5'b10001;
        @(posedge clk);
        @(negedge clk);
        int_req_set = '0;
        wait_acc(20, got, gi, gl);
        check(got && gi == 3, "R11 (first winner)", gi, 3);
        wait_acc(20, got, gi, gl);
        check(got && gi == 7 && gl == 3, "R11 (loser taken next)", gi, 7);
        count_acc(20, cnt, li);
        check(cnt == 0, "R11 (both cleared)", cnt, 0);

        summary();
        $finish;
    end
endmodule